// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block runs the entry and return sequences of a small processor's interrupt system. It watches 32 request lines and a software-interrupt request. It waits until the instruction cycle reaches its execute stage. It then saves state on a stack kept in memory and sends the processor to a handler. The handler address comes from a vector word in memory, and that word's address is the interrupt number. On entry the block first pushes the current enable mask and then the return program counter, and it clears every enable bit. A return command pops both words back, restores the mask and the program counter, and moves the stack pointer back up by two.

The stack pointer is an ordinary register in the processor's register file. A mask-set command tells the block which register that is, and the block reports the choice on `isp_sel`. The register file supplies that register's value on `sp_val` and applies the updates the block requests. The same command loads the enable mask from a register value, from a 16-bit immediate, or from a memory word. The memory has a two-cycle read latency. The block drives that memory's single address, write-data and write-enable port while a sequence runs.

Top module: `isr_sequencer`

## Requirements
- R1: Request line 0 is kept for reset and never starts an entry, whatever the mask holds. Lines 1 to 31 start an entry only while their `irq_mask` bit is 1.
- R2: If several enabled lines are pending, the lowest-numbered line is served. A software request in the same cycle wins over all hardware lines.
- R3: After a request is latched, no memory write happens until `exec_stage` has been sampled high. The first entry write appears in the cycle right after that sample.
- R4: Entry writes the old mask at address `sp_val`, and in the next cycle writes the return PC (`pc_cur` as sampled with `exec_stage`) at `sp_val`-1. The stack pointer ends two below its start.
- R5: From the cycle after the PC write, `irq_mask` reads all zeros, and it stays zero until a return or a mask-set command changes it.
- R6: `pc_load` pulses for one cycle with the vector word read from the address equal to the interrupt number. The pulse comes five cycles after the first entry write.
- R7: A return command (`rti_cmd`, sampled in cycle c) reads the PC from SP+1 and the mask from SP+2. It pulses `pc_load` in cycle c+4, shows the restored mask from cycle c+5, and writes SP+2 back.
- R8: A software request takes its interrupt number from `swi_num` and runs the same entry sequence as a hardware line.
- R9: A mask-set command with source code 0 (register), or code 3, loads `irq_mask` from `mset_reg_val`. Every mask-set command records `mset_reg` on `isp_sel`. Both are visible in the cycle after the command.
- R10: A mask-set command with source code 1 (immediate) loads `irq_mask` with `mset_imm` zero-extended, so bits 31:16 read 0.
- R11: A mask-set command with source code 2 (memory) reads the word at address `mset_imm`. That word appears on `irq_mask` four cycles after the command cycle, and the old mask stays until then.
- R12: Commands and requests are accepted only while the block is idle. A mask-set command issued during an entry leaves the cleared mask at zero.
- R13: After reset, `irq_mask` is zero, `isp_sel` is zero, and neither `mem_we` nor `pc_load` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Hardware request lines, bit n is interrupt n |
| swi_req | input | 1 | Software interrupt request |
| swi_num | input | 5 | Interrupt number for the software request |
| rti_cmd | input | 1 | Return-from-interrupt command |
| mset_cmd | input | 1 | Mask-set command |
| mset_src | input | 2 | Mask source: 0 register, 1 immediate, 2 memory, 3 register |
| mset_reg | input | 4 | Register index to use as the interrupt stack pointer |
| mset_reg_val | input | 32 | Register value for the register mask source |
| mset_imm | input | 16 | Immediate mask value, or memory address for the memory source |
| exec_stage | input | 1 | Instruction cycle is in its execute stage |
| pc_cur | input | 12 | Return program counter supplied by the instruction cycle |
| sp_val | input | 32 | Current value of the interrupt stack pointer register |
| mem_rdata | input | 32 | Memory read data, two cycles after the address |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp_wr_en | output | 1 | Stack pointer register update strobe |
| sp_wr_data | output | 32 | New stack pointer value |
| isp_sel | output | 4 | Index of the register serving as interrupt stack pointer |
| pc_load | output | 1 | Load the program counter |
| pc_load_addr | output | 12 | Program counter value to load |
| irq_mask | output | 32 | Interrupt enable mask, 1 enables a line |

## Verification
The tests feed a wrong number, a wrong stack address or a wrong word into the sequence. A stale stack copy, a misrouted vector index or a write done one state early shows on `mem_addr`, `mem_wdata` and `mem_we` within the two entry write cycles. A wrong latched interrupt number only shows when `pc_load_addr` is compared with the expected vector word, five cycles after the first write. A wrong mask, or a read that comes back in the wrong cycle, may stay hidden until a return or a later request depends on it. So the bench checks `irq_mask` in the exact cycle each load should land, and once more after each return.

// File: rtl/isr_pkg.sv
package isr_pkg;

  // Sequencer states: entry path, return path, memory mask-load path
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_EX,
    ST_SAVE,
    ST_CLEAR,
    ST_VEC,
    ST_VW1,
    ST_VW2,
    ST_JUMP,
    ST_DONE,
    ST_RET_PC,
    ST_RET_MSK,
    ST_RET_WAIT,
    ST_RET_END,
    ST_MSK_RD,
    ST_MSK_W1,
    ST_MSK_W2
  } seq_state_t;

  // Source select for the mask-set command
  typedef enum logic [1:0] {
    MSRC_REG = 2'd0,
    MSRC_IMM = 2'd1,
    MSRC_MEM = 2'd2,
    MSRC_ALT = 2'd3
  } msk_src_t;

endpackage

// File: rtl/isr_rst_sync.sv
module isr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic meta_q;

  // Asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end

endmodule

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_W   = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic [NUM_IRQ-1:0] en,
  output logic               found,
  output logic [NUM_W-1:0]   idx
);

  // Line 0 belongs to the reset path and is never served here
  localparam logic LINE0_TAKEN = 1'b0;

  logic [NUM_IRQ-1:0] elig;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
    if (g == 0) begin : g_reset_line
      assign elig[g] = req[g] & en[g] & LINE0_TAKEN;
    end else begin : g_line
      assign elig[g] = req[g] & en[g];
    end
  end

  // Scan from the top so the lowest eligible line is the last write
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = NUM_W'(i);
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_LOWEST_WINS: assert (req[idx] && en[idx] &&
        ((elig & ((NUM_IRQ'(1) << idx) - NUM_IRQ'(1))) == '0))
        else $error("picked line is not the lowest enabled one"); // R2
      AST_LINE0_NEVER: assert (idx != '0)
        else $error("reset line selected"); // R1
    end
  end

endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int NUM_IRQ = 32,
  parameter int REG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ld_en,
  input  logic [NUM_IRQ-1:0] ld_val,
  input  logic               isp_ld,
  input  logic [REG_W-1:0]   isp_val,
  output logic [NUM_IRQ-1:0] mask,
  output logic [REG_W-1:0]   isp_sel
);

  logic [NUM_IRQ-1:0] mask_d;
  logic [REG_W-1:0]   isp_d;

  always_comb begin
    mask_d = mask;
    isp_d  = isp_sel;
    if (clr) begin
      mask_d = '0;
    end else if (ld_en) begin
      mask_d = ld_val;
    end
    if (isp_ld) begin
      isp_d = isp_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      isp_sel <= '0;
    end else begin
      mask    <= mask_d;
      isp_sel <= isp_d;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0)) else $error("mask not cleared on entry"); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_en) |=> $stable(mask)) else $error("mask moved without a load"); // R12

endmodule

// File: rtl/isr_seq_ctrl.sv
module isr_seq_ctrl
  import isr_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int IMM_W   = 16,
  parameter int NUM_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pick_found,
  input  logic [NUM_W-1:0]   pick_idx,
  input  logic               swi_req,
  input  logic [NUM_W-1:0]   swi_num,
  input  logic               rti_cmd,
  input  logic               mset_cmd,
  input  msk_src_t           mset_src,
  input  logic [DATA_W-1:0]  mset_reg_val,
  input  logic [IMM_W-1:0]   mset_imm,
  input  logic               exec_stage,
  input  logic [ADDR_W-1:0]  pc_cur,
  input  logic [DATA_W-1:0]  sp_val,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [NUM_IRQ-1:0] irq_mask,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_we,
  output logic               sp_wr_en,
  output logic [DATA_W-1:0]  sp_wr_data,
  output logic               pc_load,
  output logic [ADDR_W-1:0]  pc_load_addr,
  output logic               mask_clr,
  output logic               mask_ld_en,
  output logic [NUM_IRQ-1:0] mask_ld_val,
  output logic               isp_ld
);

  seq_state_t        state_q, state_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [DATA_W-1:0] sp_q, sp_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] imm_q, imm_d;
  logic [ADDR_W-1:0] word_q, word_d;

  always_comb begin
    state_d      = state_q;
    num_d        = num_q;
    sp_d         = sp_q;
    pc_d         = pc_q;
    imm_d        = imm_q;
    word_d       = word_q;
    mem_addr     = '0;
    mem_wdata    = '0;
    mem_we       = 1'b0;
    sp_wr_en     = 1'b0;
    sp_wr_data   = '0;
    pc_load      = 1'b0;
    pc_load_addr = '0;
    mask_clr     = 1'b0;
    mask_ld_en   = 1'b0;
    mask_ld_val  = '0;
    isp_ld       = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (rti_cmd) begin
          state_d = ST_RET_PC;
        end else if (mset_cmd) begin
          isp_ld = 1'b1;
          unique case (mset_src)
            MSRC_IMM: begin
              mask_ld_en  = 1'b1;
              mask_ld_val = NUM_IRQ'(mset_imm);
            end
            MSRC_MEM: begin
              imm_d   = ADDR_W'(mset_imm);
              state_d = ST_MSK_RD;
            end
            default: begin
              mask_ld_en  = 1'b1;
              mask_ld_val = NUM_IRQ'(mset_reg_val);
            end
          endcase
        end else if (swi_req) begin
          num_d   = swi_num;
          state_d = ST_WAIT_EX;
        end else if (pick_found) begin
          num_d   = pick_idx;
          state_d = ST_WAIT_EX;
        end
      end
      ST_WAIT_EX: begin
        if (exec_stage) begin
          pc_d    = pc_cur;
          state_d = ST_SAVE;
        end
      end
      ST_SAVE: begin
        mem_addr   = sp_val[ADDR_W-1:0];
        mem_wdata  = DATA_W'(irq_mask);
        mem_we     = 1'b1;
        sp_d       = sp_val - 1'b1;
        sp_wr_en   = 1'b1;
        sp_wr_data = sp_val - 1'b1;
        state_d    = ST_CLEAR;
      end
      ST_CLEAR: begin
        mem_addr   = sp_q[ADDR_W-1:0];
        mem_wdata  = DATA_W'(pc_q);
        mem_we     = 1'b1;
        sp_d       = sp_q - 1'b1;
        sp_wr_en   = 1'b1;
        sp_wr_data = sp_q - 1'b1;
        mask_clr   = 1'b1;
        state_d    = ST_VEC;
      end
      ST_VEC: begin
        mem_addr = ADDR_W'(num_q);
        state_d  = ST_VW1;
      end
      ST_VW1: state_d = ST_VW2;
      ST_VW2: begin
        word_d  = mem_rdata[ADDR_W-1:0];
        state_d = ST_JUMP;
      end
      ST_JUMP: begin
        pc_load      = 1'b1;
        pc_load_addr = word_q;
        state_d      = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      ST_RET_PC: begin
        mem_addr = sp_val[ADDR_W-1:0] + 1'b1;
        sp_d     = sp_val;
        state_d  = ST_RET_MSK;
      end
      ST_RET_MSK: begin
        mem_addr = sp_q[ADDR_W-1:0] + 2'd2;
        state_d  = ST_RET_WAIT;
      end
      ST_RET_WAIT: begin
        word_d  = mem_rdata[ADDR_W-1:0];
        state_d = ST_RET_END;
      end
      ST_RET_END: begin
        pc_load      = 1'b1;
        pc_load_addr = word_q;
        mask_ld_en   = 1'b1;
        mask_ld_val  = NUM_IRQ'(mem_rdata);
        sp_wr_en     = 1'b1;
        sp_wr_data   = sp_q + 2'd2;
        state_d      = ST_IDLE;
      end
      ST_MSK_RD: begin
        mem_addr = imm_q;
        state_d  = ST_MSK_W1;
      end
      ST_MSK_W1: state_d = ST_MSK_W2;
      ST_MSK_W2: begin
        mask_ld_en  = 1'b1;
        mask_ld_val = NUM_IRQ'(mem_rdata);
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      num_q   <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      imm_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      num_q   <= num_d;
      sp_q    <= sp_d;
      pc_q    <= pc_d;
      imm_q   <= imm_d;
      word_q  <= word_d;
    end
  end

  AST_WRITE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAVE) |-> $past(exec_stage)) else $error("entry began outside execute"); // R3

  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> (mem_we && (mem_addr == $past(mem_addr) - 1'b1)))
    else $error("second stack write not one word below"); // R4

  AST_JUMP_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_JUMP) |-> (irq_mask == '0)) else $error("handler entered with mask set"); // R5

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load) else $error("pc_load longer than one cycle"); // R6

endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer
  import isr_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int REG_W   = 4,
  parameter int IMM_W   = 16,
  localparam int NUM_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               swi_req,
  input  logic [NUM_W-1:0]   swi_num,
  input  logic               rti_cmd,
  input  logic               mset_cmd,
  input  logic [1:0]         mset_src,
  input  logic [REG_W-1:0]   mset_reg,
  input  logic [DATA_W-1:0]  mset_reg_val,
  input  logic [IMM_W-1:0]   mset_imm,
  input  logic               exec_stage,
  input  logic [ADDR_W-1:0]  pc_cur,
  input  logic [DATA_W-1:0]  sp_val,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_we,
  output logic               sp_wr_en,
  output logic [DATA_W-1:0]  sp_wr_data,
  output logic [REG_W-1:0]   isp_sel,
  output logic               pc_load,
  output logic [ADDR_W-1:0]  pc_load_addr,
  output logic [NUM_IRQ-1:0] irq_mask
);

  logic               rst_n_s;
  logic               pick_found;
  logic [NUM_W-1:0]   pick_idx;
  logic               mask_clr;
  logic               mask_ld_en;
  logic [NUM_IRQ-1:0] mask_ld_val;
  logic               isp_ld;
  msk_src_t           src_sel;

  assign src_sel = msk_src_t'(mset_src);

  isr_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  isr_prio_pick #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) u_pick (
    .req   (irq_req),
    .en    (irq_mask),
    .found (pick_found),
    .idx   (pick_idx)
  );

  isr_seq_ctrl #(
    .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IMM_W(IMM_W), .NUM_W(NUM_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .pick_found   (pick_found),
    .pick_idx     (pick_idx),
    .swi_req      (swi_req),
    .swi_num      (swi_num),
    .rti_cmd      (rti_cmd),
    .mset_cmd     (mset_cmd),
    .mset_src     (src_sel),
    .mset_reg_val (mset_reg_val),
    .mset_imm     (mset_imm),
    .exec_stage   (exec_stage),
    .pc_cur       (pc_cur),
    .sp_val       (sp_val),
    .mem_rdata    (mem_rdata),
    .irq_mask     (irq_mask),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .sp_wr_en     (sp_wr_en),
    .sp_wr_data   (sp_wr_data),
    .pc_load      (pc_load),
    .pc_load_addr (pc_load_addr),
    .mask_clr     (mask_clr),
    .mask_ld_en   (mask_ld_en),
    .mask_ld_val  (mask_ld_val),
    .isp_ld       (isp_ld)
  );

  isr_mask_reg #(.NUM_IRQ(NUM_IRQ), .REG_W(REG_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (mask_clr),
    .ld_en   (mask_ld_en),
    .ld_val  (mask_ld_val),
    .isp_ld  (isp_ld),
    .isp_val (mset_reg),
    .mask    (irq_mask),
    .isp_sel (isp_sel)
  );

endmodule

// File: tb/isr_sequencer_tb_top.sv
`timescale 1ns/1ps
module isr_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_req;
  logic        swi_req;
  logic [4:0]  swi_num;
  logic        rti_cmd;
  logic        mset_cmd;
  logic [1:0]  mset_src;
  logic [3:0]  mset_reg;
  logic [31:0] mset_reg_val;
  logic [15:0] mset_imm;
  logic        exec_stage;
  logic [11:0] pc_cur;
  logic [31:0] sp_val;
  logic [31:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic        sp_wr_en;
  logic [31:0] sp_wr_data;
  logic [3:0]  isp_sel;
  logic        pc_load;
  logic [11:0] pc_load_addr;
  logic [31:0] irq_mask;

  always #10 clk = ~clk;

  isr_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
    .swi_num(swi_num), .rti_cmd(rti_cmd), .mset_cmd(mset_cmd),
    .mset_src(mset_src), .mset_reg(mset_reg), .mset_reg_val(mset_reg_val),
    .mset_imm(mset_imm), .exec_stage(exec_stage), .pc_cur(pc_cur),
    .sp_val(sp_val), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .sp_wr_en(sp_wr_en),
    .sp_wr_data(sp_wr_data), .isp_sel(isp_sel), .pc_load(pc_load),
    .pc_load_addr(pc_load_addr), .irq_mask(irq_mask)
  );

  // Behavioural memory, two-cycle read latency, plus a bench preload port
  logic [31:0] mem [0:255];
  logic [31:0] rd_p1, rd_p2;
  logic        pk_en;
  logic [7:0]  pk_addr;
  logic [31:0] pk_data;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    else if (pk_en) mem[pk_addr] <= pk_data;
    rd_p1 <= mem[mem_addr[7:0]];
    rd_p2 <= rd_p1;
  end
  assign mem_rdata = rd_p2;

  // Stack pointer register of the surrounding register file
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_val <= 32'h80;
    else if (sp_wr_en) sp_val <= sp_wr_data;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event log sampled mid-cycle
  int          wr_n = 0;
  int          pl_n = 0;
  logic [11:0] wr_addr [0:63];
  logic [31:0] wr_data [0:63];
  int          wr_cyc  [0:63];
  logic [11:0] pl_val  [0:63];
  int          pl_cyc  [0:63];

  always @(negedge clk) begin
    if (mem_we && wr_n < 64) begin
      wr_addr[wr_n] = mem_addr;
      wr_data[wr_n] = mem_wdata;
      wr_cyc[wr_n]  = cyc;
      wr_n = wr_n + 1;
    end
    if (pc_load && pl_n < 64) begin
      pl_val[pl_n] = pc_load_addr;
      pl_cyc[pl_n] = cyc;
      pl_n = pl_n + 1;
    end
  end

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    pk_en = 1'b1; pk_addr = a; pk_data = d;
    step();
    pk_en = 1'b0;
  endtask

  task automatic mask_cmd(input logic [1:0] src, input logic [3:0] r,
                          input logic [31:0] rv, input logic [15:0] imm);
    mset_cmd = 1'b1; mset_src = src; mset_reg = r; mset_reg_val = rv; mset_imm = imm;
    step();
    mset_cmd = 1'b0;
  endtask

  // Return sequence with full timing checks
  task automatic do_rti(input logic [11:0] exp_pc, input logic [31:0] exp_mask, input string tag);
    int cr, pb;
    pb = pl_n;
    cr = cyc;
    rti_cmd = 1'b1;
    step();
    rti_cmd = 1'b0;
    steps(3);
    chk({"R7 mask held before restore ", tag}, irq_mask, 32'h0);
    step();
    chk({"R7 mask restored ", tag}, irq_mask, exp_mask);
    steps(2);
    chk({"R7 pc_load count ", tag}, 32'(pl_n - pb), 32'd1);
    chk({"R7 pc_load cycle ", tag}, 32'(pl_cyc[pb]), 32'(cr + 4));
    chk({"R7 restored pc ", tag}, 32'(pl_val[pb]), 32'(exp_pc));
    chk({"R7 stack pointer ", tag}, sp_val, 32'h80);
  endtask

  task automatic t_reset();
    chk("R13 mask after reset", irq_mask, 32'h0);
    chk("R13 isp_sel after reset", 32'(isp_sel), 32'h0);
    chk("R13 no write after reset", 32'(mem_we), 32'h0);
    chk("R13 no pc_load after reset", 32'(pc_load), 32'h0);
  endtask

  task automatic t_mask_reg();
    mask_cmd(2'd0, 4'd14, 32'h0000_0060, 16'hFFFF);
    chk("R9 mask from register", irq_mask, 32'h0000_0060);
    chk("R9 isp_sel recorded", 32'(isp_sel), 32'd14);
  endtask

  task automatic t_hw_entry();
    int ce, wb, pb;
    poke(8'd5, 32'h0000_0123);
    poke(8'd6, 32'h0000_0166);
    wb = wr_n; pb = pl_n;
    pc_cur = 12'h345;
    irq_req = 32'h0000_0061;
    exec_stage = 1'b0;
    steps(4);
    chk("R3 no write before execute", 32'(wr_n - wb), 32'd0);
    exec_stage = 1'b1;
    ce = cyc;
    step();
    exec_stage = 1'b0;
    irq_req = 32'h0;
    steps(2);
    mset_cmd = 1'b1; mset_src = 2'd0; mset_reg_val = 32'hFFFF_FFFF; mset_reg = 4'd14;
    step();
    mset_cmd = 1'b0;
    steps(5);
    chk("R4 write count", 32'(wr_n - wb), 32'd2);
    chk("R3 first write cycle", 32'(wr_cyc[wb]), 32'(ce + 1));
    chk("R4 mask word address", 32'(wr_addr[wb]), 32'h80);
    chk("R4 mask word data", wr_data[wb], 32'h0000_0060);
    chk("R4 pc word cycle", 32'(wr_cyc[wb + 1]), 32'(ce + 2));
    chk("R4 pc word address", 32'(wr_addr[wb + 1]), 32'h7F);
    chk("R4 pc word data", wr_data[wb + 1], 32'h0000_0345);
    chk("R4 stack pointer after entry", sp_val, 32'h7E);
    chk("R6 pc_load count", 32'(pl_n - pb), 32'd1);
    chk("R6 pc_load cycle", 32'(pl_cyc[pb]), 32'(ce + 6));
    chk("R2 vector of lowest line", 32'(pl_val[pb]), 32'h123);
    chk("R5 R12 mask cleared and command ignored", irq_mask, 32'h0);
    do_rti(12'h345, 32'h0000_0060, "after hw entry");
  endtask

  task automatic t_lowest();
    int wb, pb;
    poke(8'd4, 32'h0000_0444);
    mask_cmd(2'd0, 4'd14, 32'hFFFF_FFFF, 16'h0);
    wb = wr_n; pb = pl_n;
    pc_cur = 12'h222;
    irq_req = 32'h0000_0031;
    exec_stage = 1'b1;
    step();
    irq_req = 32'h0;
    steps(10);
    exec_stage = 1'b0;
    chk("R2 lowest enabled line above 0", 32'(pl_val[pb]), 32'h444);
    chk("R4 full mask saved", wr_data[wb], 32'hFFFF_FFFF);
    do_rti(12'h222, 32'hFFFF_FFFF, "after lowest");
  endtask

  task automatic t_line0();
    int wb, pb;
    wb = wr_n; pb = pl_n;
    irq_req = 32'h0000_0001;
    exec_stage = 1'b1;
    steps(10);
    irq_req = 32'h0;
    exec_stage = 1'b0;
    step();
    chk("R1 line 0 causes no write", 32'(wr_n - wb), 32'd0);
    chk("R1 line 0 causes no pc_load", 32'(pl_n - pb), 32'd0);
  endtask

  task automatic t_mask_imm_and_gate();
    int wb, pb;
    mask_cmd(2'd1, 4'd9, 32'hFFFF_FFFF, 16'hABCD);
    chk("R10 immediate zero-extended", irq_mask, 32'h0000_ABCD);
    chk("R9 isp_sel from immediate command", 32'(isp_sel), 32'd9);
    wb = wr_n; pb = pl_n;
    irq_req = 32'h0000_0003;
    exec_stage = 1'b1;
    steps(10);
    irq_req = 32'h0;
    exec_stage = 1'b0;
    step();
    chk("R1 disabled line ignored (writes)", 32'(wr_n - wb), 32'd0);
    chk("R1 disabled line ignored (pc_load)", 32'(pl_n - pb), 32'd0);
  endtask

  task automatic t_swi();
    int wb, pb;
    poke(8'd9, 32'h0000_0999);
    poke(8'd3, 32'h0000_0333);
    mask_cmd(2'd3, 4'd14, 32'h0000_0008, 16'h0);
    chk("R9 source code 3 uses register", irq_mask, 32'h0000_0008);
    wb = wr_n; pb = pl_n;
    pc_cur = 12'h0AB;
    irq_req = 32'h0000_0008;
    swi_req = 1'b1; swi_num = 5'd9;
    exec_stage = 1'b1;
    step();
    swi_req = 1'b0;
    irq_req = 32'h0;
    steps(10);
    exec_stage = 1'b0;
    chk("R8 R2 software number wins", 32'(pl_val[pb]), 32'h999);
    chk("R8 mask saved on software entry", wr_data[wb], 32'h0000_0008);
    chk("R8 pc saved on software entry", wr_data[wb + 1], 32'h0000_00AB);
    do_rti(12'h0AB, 32'h0000_0008, "after software entry");
  endtask

  task automatic t_mask_mem();
    poke(8'h40, 32'h1234_5678);
    mask_cmd(2'd2, 4'd15, 32'hFFFF_FFFF, 16'h0040);
    steps(2);
    chk("R11 old mask kept during read", irq_mask, 32'h0000_0008);
    step();
    chk("R11 mask from memory", irq_mask, 32'h1234_5678);
    chk("R9 isp_sel from memory command", 32'(isp_sel), 32'd15);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    rst_n = 1'b0; irq_req = '0; swi_req = 1'b0; swi_num = '0; rti_cmd = 1'b0;
    mset_cmd = 1'b0; mset_src = '0; mset_reg = '0; mset_reg_val = '0; mset_imm = '0;
    exec_stage = 1'b0; pc_cur = '0; pk_en = 1'b0; pk_addr = '0; pk_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5_A5A5;
    steps(3);
    rst_n = 1'b1;
    steps(4);
    t_reset();
    t_mask_reg();
    t_hw_entry();
    t_lowest();
    t_line0();
    t_mask_imm_and_gate();
    t_swi();
    t_mask_mem();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

endmodule